// File: doc/BRIEF.md
# Audio Sample and Frame Formatter

This block sits on the peripheral side of one audio DMA channel. Memory fetch logic pushes 32-bit words into a small local word buffer. The block unpacks those words into samples of 8, 16 or 32 bits and presents them on a valid/ready sample stream. Each sample carries sideband flags that tell the peripheral where it falls in the current frame. A frame holds 1, 2 or 4 samples.

A configuration port sets two things. The first is the sample size and the frame length. The second is a fill control word, which holds a fill limit and a request threshold, both counted in bytes. The block asks the fetch logic for more data with a refill request. That request depends on how many bytes are buffered, measured against the threshold and the limit. It does not depend on the buffer being empty.

Back-pressure works as follows. On the input side, a word is taken only in a cycle where `wr_valid` and `wr_ready` are both high. On the output side, a sample is consumed only in a cycle where `smp_valid` and `smp_ready` are both high. While `smp_valid` is high and `smp_ready` is low, the sample and its flags hold still. Samples are never dropped or repeated. The channel direction is fixed by a parameter: even channel indices transmit and odd ones receive.

Top module: `pcm_frame_packer`

## Requirements
- R1: After reset, `smp_valid` is 0, `fill_req` and `wr_ready` are 1, the sample size is 8 bits with one-sample frames, the fill limit equals the buffer capacity in bytes (4 × DEPTH) and the threshold is half of that.
- R2: A write with `cfg_sel`=0 sets the sample size from `cfg_wdata[3:0]`: 0 selects 8-bit samples, 1 selects 16-bit and 2 selects 32-bit. A sub-word sample appears zero-extended in the low bits of `smp_data`.
- R3: A write with `cfg_sel`=0 sets the frame length from `cfg_wdata[7:4]`: 0 means one sample, 1 means two and 2 means four. `smp_word_idx` counts the samples within the frame and wraps after the last one. `smp_frame_start` is 1 exactly when the index is 0.
- R4: The samples of a buffered word come out lowest byte lane first (little-endian order), and the next word is taken only after the last lane.
- R5: A reserved code in `cfg_wdata[3:0]` selects 8-bit samples. A reserved code in `cfg_wdata[7:4]` selects one-sample frames.
- R6: A write with `cfg_sel`=1 loads the fill limit from `cfg_wdata[31:16]` and the threshold from `cfg_wdata[15:0]`, both in bytes. The buffered byte count is 4 × the words in the buffer, not counting the word being unpacked. `wr_ready` is 1 only while that count plus 4 does not exceed the lesser of the limit and the capacity.
- R7: `fill_req` is 1 exactly when the buffered byte count is at or below the threshold and `wr_ready` is 1.
- R8: While `smp_valid` is 1 and `smp_ready` is 0, `smp_data`, `smp_frame_start` and `smp_word_idx` stay unchanged. Every sample is delivered exactly once, in order.
- R9: Each write with `cfg_sel`=0 restarts the frame, so the next sample carries index 0.
- R10: `chan_is_rx` is 0 for an even CHAN_INDEX (transmit) and 1 for an odd one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: size/frame word, 1: fill control word |
| cfg_wdata | input | 32 | Configuration write data |
| wr_valid | input | 1 | Fetched word is valid |
| wr_ready | output | 1 | Buffer accepts a word |
| wr_data | input | 32 | Fetched word |
| fill_req | output | 1 | Refill request to fetch logic |
| smp_valid | output | 1 | Sample is valid |
| smp_ready | input | 1 | Peripheral takes the sample |
| smp_data | output | 32 | Sample, zero-extended |
| smp_frame_start | output | 1 | Sample is the first of its frame |
| smp_word_idx | output | 2 | Position of the sample in its frame |
| chan_is_rx | output | 1 | Fixed channel direction |

## Verification
The bench goes after several corner cases:
- Lane order for each sample size. A reversed or misindexed extraction would put bytes in the wrong order.
- Index wrap at 2 and at 4. An off-by-one would show an index of 2 in two-sample frames.
- Reserved size and frame codes, which a careless decoder would turn into 32-bit samples or a stray frame length.
- A frame restart while the index is mid-frame.
- The edges of the fill logic, with the output stalled. The threshold test is inclusive. The request must drop when there is no room even if the threshold is still met. A limit larger than the buffer must be clamped to the capacity, or the buffer would overflow.

A stuttering ready pattern tests that no sample is lost or repeated.

// File: rtl/pcm_pack_pkg.sv
package pcm_pack_pkg;

  localparam int WORD_W = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2
  } smp_size_e;

  typedef enum logic [1:0] {
    FR_1 = 2'd0,
    FR_2 = 2'd1,
    FR_4 = 2'd2
  } frame_len_e;

  function automatic smp_size_e decode_size(input logic [3:0] code);
    case (code)
      4'd1:    return SZ_16;
      4'd2:    return SZ_32;
      default: return SZ_8;
    endcase
  endfunction

  function automatic frame_len_e decode_frame(input logic [3:0] code);
    case (code)
      4'd1:    return FR_2;
      4'd2:    return FR_4;
      default: return FR_1;
    endcase
  endfunction

  // index of the last sample lane inside one buffered word
  function automatic logic [1:0] last_lane(input smp_size_e sz);
    case (sz)
      SZ_8:    return 2'd3;
      SZ_16:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // index of the last sample inside one frame
  function automatic logic [1:0] last_slot(input frame_len_e fl);
    case (fl)
      FR_2:    return 2'd1;
      FR_4:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pcm_cfg_regs.sv
module pcm_cfg_regs
  import pcm_pack_pkg::*;
#(
  parameter int CAP_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output smp_size_e   size_q,
  output frame_len_e  frame_q,
  output logic [15:0] limit_q,
  output logic [15:0] thresh_q,
  output logic        restart
);

  localparam logic [15:0] LIMIT_RST  = 16'(CAP_BYTES);
  localparam logic [15:0] THRESH_RST = 16'(CAP_BYTES / 2);

  assign restart = cfg_we && !cfg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q   <= SZ_8;
      frame_q  <= FR_1;
      limit_q  <= LIMIT_RST;
      thresh_q <= THRESH_RST;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        size_q  <= decode_size(cfg_wdata[3:0]);
        frame_q <= decode_frame(cfg_wdata[7:4]);
      end else begin
        limit_q  <= cfg_wdata[31:16];
        thresh_q <= cfg_wdata[15:0];
      end
    end
  end

  // the decoders never produce the unused fourth code
  p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    size_q != smp_size_e'(2'd3));
  p_frame_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q != frame_len_e'(2'd3));

endmodule

// File: rtl/pcm_word_buf.sv
module pcm_word_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              not_empty,
  output logic [$clog2(DEPTH):0] count
);

  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  assign head      = mem[rd_ptr];
  assign not_empty = (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < ($clog2(DEPTH)+1)'(DEPTH)));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);

endmodule

// File: rtl/pcm_fill_ctrl.sv
module pcm_fill_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [$clog2(DEPTH):0] count,
  input  logic [15:0]            limit_q,
  input  logic [15:0]            thresh_q,
  input  logic                   push,
  output logic                   room,
  output logic                   fill_req
);

  localparam int          CAP_BYTES = DEPTH * 4;
  localparam logic [16:0] CAP_B     = 17'(CAP_BYTES);

  logic [16:0] occ_bytes;
  logic [16:0] limit_eff;

  assign occ_bytes = 17'(count) << 2;
  assign limit_eff = ({1'b0, limit_q} < CAP_B) ? {1'b0, limit_q} : CAP_B;
  assign room      = (occ_bytes + 17'd4) <= limit_eff;
  assign fill_req  = room && (occ_bytes <= {1'b0, thresh_q});

  p_push_within_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (occ_bytes <= $past(limit_eff)));
  p_req_has_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (count < ($clog2(DEPTH)+1)'(DEPTH)));

endmodule

// File: rtl/pcm_unpacker.sv
module pcm_unpacker
  import pcm_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  smp_size_e         size_q,
  input  frame_len_e        frame_q,
  input  logic              restart,
  input  logic              word_avail,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_pop,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [WORD_W-1:0] smp_data,
  output logic              smp_frame_start,
  output logic [1:0]        smp_word_idx
);

  logic [WORD_W-1:0] hold_q;
  logic              hold_v;
  logic [1:0]        lane_q;
  logic [1:0]        slot_q;
  logic              take, lane_end, consume;

  logic [7:0]  lane8  [WORD_BYTES];
  logic [15:0] lane16 [WORD_BYTES/2];

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_b8
    assign lane8[g] = hold_q[8*g +: 8];
  end
  for (genvar g = 0; g < WORD_BYTES/2; g++) begin : g_b16
    assign lane16[g] = hold_q[16*g +: 16];
  end

  always_comb begin
    case (size_q)
      SZ_8:    smp_data = {24'b0, lane8[lane_q]};
      SZ_16:   smp_data = {16'b0, lane16[lane_q[0]]};
      default: smp_data = hold_q;
    endcase
  end

  assign smp_valid       = hold_v;
  assign smp_word_idx    = slot_q;
  assign smp_frame_start = (slot_q == 2'd0);
  assign take            = smp_valid && smp_ready;
  assign lane_end        = (lane_q == last_lane(size_q));
  assign consume         = take && lane_end;
  assign word_pop        = word_avail && (!hold_v || consume);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else if (word_pop) begin
      hold_q <= word_data;
      hold_v <= 1'b1;
    end else if (consume) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      lane_q <= '0;
      slot_q <= '0;
    end else if (take) begin
      lane_q <= lane_end ? 2'd0 : lane_q + 2'd1;
      slot_q <= (slot_q == last_slot(frame_q)) ? 2'd0 : slot_q + 2'd1;
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && !restart) |=>
      (smp_valid && $stable(smp_data) && $stable(smp_word_idx)));
  p_idx_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_word_idx <= last_slot(frame_q)));
  p_idx_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !restart && smp_word_idx == last_slot(frame_q)) |=> smp_frame_start);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (smp_word_idx == 2'd0));

endmodule

// File: rtl/pcm_frame_packer.sv
module pcm_frame_packer
  import pcm_pack_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int CHAN_INDEX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [31:0] wr_data,
  output logic        fill_req,
  output logic        smp_valid,
  input  logic        smp_ready,
  output logic [31:0] smp_data,
  output logic        smp_frame_start,
  output logic [1:0]  smp_word_idx,
  output logic        chan_is_rx
);

  localparam int CAP_BYTES = DEPTH * WORD_BYTES;
  localparam int CW        = $clog2(DEPTH) + 1;

  smp_size_e   size_q;
  frame_len_e  frame_q;
  logic [15:0] limit_q, thresh_q;
  logic        restart;
  logic        push, pop, avail, room;
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     count;

  if (CHAN_INDEX % 2 == 0) begin : g_tx
    assign chan_is_rx = 1'b0;
  end else begin : g_rx
    assign chan_is_rx = 1'b1;
  end

  assign wr_ready = room;
  assign push     = wr_valid && room;

  pcm_cfg_regs #(.CAP_BYTES(CAP_BYTES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .size_q(size_q), .frame_q(frame_q),
    .limit_q(limit_q), .thresh_q(thresh_q), .restart(restart)
  );

  pcm_word_buf #(.DATA_W(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
    .pop(pop), .head(head), .not_empty(avail), .count(count)
  );

  pcm_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n), .count(count), .limit_q(limit_q),
    .thresh_q(thresh_q), .push(push), .room(room), .fill_req(fill_req)
  );

  pcm_unpacker u_unp (
    .clk(clk), .rst_n(rst_n), .size_q(size_q), .frame_q(frame_q),
    .restart(restart), .word_avail(avail), .word_data(head),
    .word_pop(pop), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_frame_start(smp_frame_start),
    .smp_word_idx(smp_word_idx)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!smp_valid && fill_req));

endmodule

// File: tb/pcm_frame_packer_tb_top.sv
module pcm_frame_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, fill_req, smp_valid, smp_frame_start, chan_is_rx;
  logic        smp_ready = 1'b0;
  logic [31:0] smp_data;
  logic [1:0]  smp_word_idx;

  always #2 clk = ~clk;

  pcm_frame_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .fill_req(fill_req), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data),
    .smp_frame_start(smp_frame_start), .smp_word_idx(smp_word_idx),
    .chan_is_rx(chan_is_rx)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [34:0] expq [$];
  int exp_bytes = 1;
  int exp_slots = 1;
  int exp_slot  = 0;
  int ready_mode = 1;
  int cyc = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (ready_mode)
      0: smp_ready = 1'b0;
      1: smp_ready = 1'b1;
      default: smp_ready = (cyc % 3) != 0;
    endcase
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && smp_valid && smp_ready) begin
      if (expq.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R8 actual=%0h expected=none (extra sample)", smp_data);
      end else begin
        logic [34:0] e;
        e = expq.pop_front();
        check("R2/R4 data", 64'(smp_data), 64'(e[31:0]));
        check("R3 index", 64'(smp_word_idx), 64'(e[33:32]));
        check("R3 frame start", 64'(smp_frame_start), 64'(e[34]));
      end
    end
  end

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (!sel) begin
      case (d[3:0]) 4'd1: exp_bytes = 2; 4'd2: exp_bytes = 4; default: exp_bytes = 1; endcase
      case (d[7:4]) 4'd1: exp_slots = 2; 4'd2: exp_slots = 4; default: exp_slots = 1; endcase
      exp_slot = 0;
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = w;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    for (int l = 0; l < 4 / exp_bytes; l++) begin
      logic [31:0] s;
      s = w >> (8 * exp_bytes * l);
      if (exp_bytes == 1) s = s & 32'hFF;
      else if (exp_bytes == 2) s = s & 32'hFFFF;
      expq.push_back({(exp_slot == 0), 2'(exp_slot), s});
      exp_slot = (exp_slot + 1) % exp_slots;
    end
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && (expq.size() != 0 || smp_valid); i++) @(posedge clk);
    @(negedge clk);
    check(req, 64'(expq.size()), 64'd0);
  endtask

  task automatic settle;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R10 direction
    check("R1 smp_valid", 64'(smp_valid), 64'd0);
    check("R1 fill_req", 64'(fill_req), 64'd1);
    check("R1 wr_ready", 64'(wr_ready), 64'd1);
    check("R10 chan_is_rx", 64'(chan_is_rx), 64'd0);

    // R1 default 8-bit one-sample frames, R4 lane order
    ready_mode = 1;
    push_word(32'h4433_2211);
    push_word(32'hDDCC_BBAA);
    push_word(32'h0F1E_2D3C);
    drain("R8 drain default");

    // R2 16-bit, R3 two-sample frames
    cfg_write(1'b0, 32'h11);
    ready_mode = 2;
    for (int i = 0; i < 4; i++) push_word(32'hA5A5_0000 + 32'(i * 32'h1357));
    drain("R8 drain 16-bit");

    // R2 32-bit, R3 four-sample frames, then R9 restart mid-frame
    cfg_write(1'b0, 32'h22);
    for (int i = 0; i < 6; i++) push_word(32'h1000_0001 * 32'(i + 1));
    drain("R8 drain 32-bit");
    cfg_write(1'b0, 32'h22);
    push_word(32'hCAFE_F00D);
    push_word(32'hBEEF_0123);
    drain("R9 restart drain");

    // R5 reserved codes -> 8-bit, one-sample frames
    cfg_write(1'b0, 32'h53);
    push_word(32'h8877_6655);
    push_word(32'h0102_0304);
    drain("R5 drain reserved");

    // R3 16-bit with four-sample frames
    cfg_write(1'b0, 32'h21);
    for (int i = 0; i < 3; i++) push_word(32'h0BAD_0000 | 32'(i));
    drain("R8 drain 16/4");

    // R6/R7 fill control with stalled output
    cfg_write(1'b0, 32'h02);
    cfg_write(1'b1, {16'd12, 16'd4});
    ready_mode = 0;
    push_word(32'h1111_1111); settle();
    check("R7 req at 0 bytes", 64'(fill_req), 64'd1);
    push_word(32'h2222_2222); settle();
    check("R7 req at threshold", 64'(fill_req), 64'd1);
    push_word(32'h3333_3333); settle();
    check("R7 req above threshold", 64'(fill_req), 64'd0);
    check("R6 ready below limit", 64'(wr_ready), 64'd1);
    push_word(32'h4444_4444); settle();
    check("R6 ready at limit", 64'(wr_ready), 64'd0);
    cfg_write(1'b1, {16'd12, 16'd20}); settle();
    check("R7 no room no req", 64'(fill_req), 64'd0);
    cfg_write(1'b1, {16'd16, 16'd20}); settle();
    check("R7 room and threshold", 64'(fill_req), 64'd1);
    check("R6 raised limit ready", 64'(wr_ready), 64'd1);
    ready_mode = 1;
    drain("R8 drain after stall");
    check("R7 req when empty", 64'(fill_req), 64'd1);

    // R6 limit clamped to capacity
    cfg_write(1'b1, 32'hFFFF_FFFF);
    ready_mode = 0;
    for (int i = 0; i < 9; i++) push_word(32'h5000_0000 + 32'(i));
    settle();
    check("R6 capacity clamp", 64'(wr_ready), 64'd0);
    check("R7 full no req", 64'(fill_req), 64'd0);
    ready_mode = 2;
    drain("R8 drain capacity");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule